// File: doc/BRIEF.md
# Banked Split-Half Register File

This block is the register storage for a datapath whose ALU works on 16-bit words while its architectural registers are 32 bits wide. Every register is kept as two 16-bit halves. A 16-bit instruction sees the file as 64 independent half-registers. A 32-bit write fills both halves of one register at once. Three combinational read ports, each addressing one half-register, feed operand fetch. The third port is meant to supply the second half of a 32-bit address. One write port updates the file at the clock edge, and a read that hits the half being written returns the new value in the same cycle.

The storage is replicated in several banks. A bank-switch command chooses which bank every later read and write uses. Ordinary writes touch only the active bank, including both halves of a full-width write. A dedicated copy operation, used when a register is moved onto itself, takes the register's value from the active bank and broadcasts it to that register in every bank. Register zero is held at zero by forcing its write data to zero rather than masking reads, so the read path carries no special case.

Top module: `rfb_regfile`

## Requirements
- R1: After a synchronous active-low reset every half-register of every bank reads zero and bank 0 is active.
- R2: A 16-bit write (`wr_kind` = 0) stores `wr_data[15:0]` into the half addressed by `wr_addr` = {register[4:0], half}, in the active bank only. The value is readable from the next cycle, and no other half or bank changes.
- R3: A full write (`wr_kind` = 1) to register `wr_addr[5:1]` stores `wr_data[15:0]` in half 0 and `wr_data[31:16]` in half 1 of that register. `wr_addr[0]` is ignored.
- R4: The upper half of a full write lands in the active bank only. The same register in any other bank keeps its previous value.
- R5: Any write to either half of register 0 stores zero, so reads of register 0 always return zero.
- R6: A read whose address equals the half being written in that cycle returns the new, zero-forced value in the same cycle, on every read port.
- R7: The three read ports return independent half-registers in the same cycle.
- R8: With `bank_sw_en` high, `bank_sw_val` becomes the active bank from the next cycle. A write issued in that same cycle still goes to the previously active bank.
- R9: A copy (`wr_kind` = 2) reads both halves of register `wr_addr[5:1]` from the active bank and writes them into that register in all banks. `wr_data` is ignored.
- R10: `wr_kind` = 3 performs no write, even with `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | 0 half, 1 full, 2 copy to all banks, 3 none |
| wr_addr | input | 6 | Write address {register, half} |
| wr_data | input | 32 | Write data; the low 16 bits are used for a half write |
| bank_sw_en | input | 1 | Load the active bank |
| bank_sw_val | input | 2 | New active bank |
| rd_addr_a | input | 6 | Read port A address {register, half} |
| rd_addr_b | input | 6 | Read port B address |
| rd_addr_c | input | 6 | Read port C address |
| rd_data_a | output | 16 | Read port A data |
| rd_data_b | output | 16 | Read port B data |
| rd_data_c | output | 16 | Read port C data |

## Verification
Read data is combinational from the address and from any write in the same cycle. A write or a copy becomes visible in storage one clock edge after it is presented. A bank switch changes the active bank at that same edge. The bench drives every input just after a falling edge and samples the read ports one time unit later. This places each check either in the cycle of a write, to test the bypass, or in a later cycle after the write's rising edge, to test storage. Bank isolation and broadcast copies are checked by switching banks and reading back through the ports.

// File: rtl/rfb_pkg.sv
// Package rfb_pkg
// Shared types for the banked split-half register file.
// Assumes the write-kind code is carried on a 2-bit port.
package rfb_pkg;
    typedef enum logic [1:0] {
        WK_HALF = 2'd0,
        WK_FULL = 2'd1,
        WK_COPY = 2'd2,
        WK_NONE = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/rfb_write_ctrl.sv
// Module rfb_write_ctrl
// Turns one write request into per-half enables and lane values.
// Forces register zero to zero and selects copy data for broadcast copies.
// Assumes cur_lo and cur_hi are the active bank's halves of the addressed register.
module rfb_write_ctrl
    import rfb_pkg::*;
#(
    parameter int HALF_W  = 16,
    parameter int REG_AW  = 5,
    localparam int HALF_AW = REG_AW + 1
) (
    input  logic                  wr_en,
    input  logic [1:0]            wr_kind,
    input  logic [HALF_AW-1:0]    wr_addr,
    input  logic [2*HALF_W-1:0]   wr_data,
    input  logic [HALF_W-1:0]     cur_lo,
    input  logic [HALF_W-1:0]     cur_hi,
    output logic                  lo_en,
    output logic                  hi_en,
    output logic                  all_banks,
    output logic [REG_AW-1:0]     reg_idx,
    output logic [HALF_W-1:0]     lo_val,
    output logic [HALF_W-1:0]     hi_val
);
    // Decode the kind into enables and lane data, then zero register 0.
    always_comb begin
        reg_idx   = wr_addr[HALF_AW-1:1];
        lo_en     = 1'b0;
        hi_en     = 1'b0;
        all_banks = 1'b0;
        lo_val    = wr_data[HALF_W-1:0];
        hi_val    = wr_data[2*HALF_W-1:HALF_W];
        case (wr_kind_e'(wr_kind))
            WK_HALF: begin
                if (wr_addr[0]) begin
                    hi_en  = wr_en;
                    hi_val = wr_data[HALF_W-1:0];
                end else begin
                    lo_en  = wr_en;
                end
            end
            WK_FULL: begin
                lo_en = wr_en;
                hi_en = wr_en;
            end
            WK_COPY: begin
                lo_en     = wr_en;
                hi_en     = wr_en;
                all_banks = wr_en;
                lo_val    = cur_lo;
                hi_val    = cur_hi;
            end
            default: begin
                lo_en = 1'b0;
                hi_en = 1'b0;
            end
        endcase
        if (reg_idx == '0) begin
            lo_val = '0;
            hi_val = '0;
        end
    end
endmodule

// File: rtl/rfb_bank.sv
// Module rfb_bank
// One bank of half-register storage, flop based, synchronously cleared.
// Assumes the parent raises sel when this bank is a write target.
module rfb_bank #(
    parameter int HALF_W   = 16,
    parameter int NUM_REGS = 32,
    localparam int REG_AW  = $clog2(NUM_REGS),
    localparam int NUM_HALVES = 2 * NUM_REGS
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               sel,
    input  logic                               lo_en,
    input  logic                               hi_en,
    input  logic [REG_AW-1:0]                  reg_idx,
    input  logic [HALF_W-1:0]                  lo_val,
    input  logic [HALF_W-1:0]                  hi_val,
    output logic [NUM_HALVES-1:0][HALF_W-1:0]  halves
);
    // Clear on reset, otherwise update the enabled halves of the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halves <= '0;
        end else if (sel) begin
            if (lo_en) halves[{reg_idx, 1'b0}] <= lo_val;
            if (hi_en) halves[{reg_idx, 1'b1}] <= hi_val;
        end
    end
endmodule

// File: rtl/rfb_read_port.sv
// Module rfb_read_port
// One combinational read port with write-through bypass.
// Assumes every write includes the active bank, so a matching write always bypasses.
module rfb_read_port #(
    parameter int HALF_W   = 16,
    parameter int NUM_REGS = 32,
    localparam int REG_AW  = $clog2(NUM_REGS),
    localparam int HALF_AW = REG_AW + 1,
    localparam int NUM_HALVES = 2 * NUM_REGS
) (
    input  logic [NUM_HALVES-1:0][HALF_W-1:0]  halves,
    input  logic [HALF_AW-1:0]                 rd_addr,
    input  logic                               lo_en,
    input  logic                               hi_en,
    input  logic [REG_AW-1:0]                  reg_idx,
    input  logic [HALF_W-1:0]                  lo_val,
    input  logic [HALF_W-1:0]                  hi_val,
    output logic [HALF_W-1:0]                  rd_data
);
    // Select stored data, overridden by an in-flight write to the same half.
    always_comb begin
        rd_data = halves[rd_addr];
        if (lo_en && (rd_addr == {reg_idx, 1'b0})) begin
            rd_data = lo_val;
        end else if (hi_en && (rd_addr == {reg_idx, 1'b1})) begin
            rd_data = hi_val;
        end
    end
endmodule

// File: rtl/rfb_regfile.sv
// Module rfb_regfile (top)
// Banked register file of 32-bit registers stored as 16-bit halves,
// three read ports, one write port, write-through, bank switching and
// broadcast copy. Assumes one write request per cycle.
module rfb_regfile #(
    parameter int HALF_W    = 16,
    parameter int NUM_REGS  = 32,
    parameter int NUM_BANKS = 4,
    localparam int REG_AW   = $clog2(NUM_REGS),
    localparam int HALF_AW  = REG_AW + 1,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int NUM_HALVES = 2 * NUM_REGS,
    localparam int NUM_RD   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_kind,
    input  logic [HALF_AW-1:0]    wr_addr,
    input  logic [2*HALF_W-1:0]   wr_data,
    input  logic                  bank_sw_en,
    input  logic [BANK_W-1:0]     bank_sw_val,
    input  logic [HALF_AW-1:0]    rd_addr_a,
    input  logic [HALF_AW-1:0]    rd_addr_b,
    input  logic [HALF_AW-1:0]    rd_addr_c,
    output logic [HALF_W-1:0]     rd_data_a,
    output logic [HALF_W-1:0]     rd_data_b,
    output logic [HALF_W-1:0]     rd_data_c
);
    logic [BANK_W-1:0]                                 active_bank;
    logic [NUM_BANKS-1:0][NUM_HALVES-1:0][HALF_W-1:0]  bank_halves;
    logic [NUM_HALVES-1:0][HALF_W-1:0]                 active_halves;
    logic                  lo_en, hi_en, all_banks;
    logic [REG_AW-1:0]     reg_idx;
    logic [HALF_W-1:0]     lo_val, hi_val, cur_lo, cur_hi;
    logic [NUM_RD-1:0][HALF_AW-1:0] rd_addr_arr;
    logic [NUM_RD-1:0][HALF_W-1:0]  rd_data_arr;

    // Hold the active bank; a switch takes effect at the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_bank <= '0;
        end else if (bank_sw_en) begin
            active_bank <= bank_sw_val;
        end
    end

    // Pick the active bank's storage and the addressed register's current halves.
    always_comb begin
        active_halves = bank_halves[active_bank];
        cur_lo        = active_halves[{wr_addr[HALF_AW-1:1], 1'b0}];
        cur_hi        = active_halves[{wr_addr[HALF_AW-1:1], 1'b1}];
    end

    rfb_write_ctrl #(
        .HALF_W (HALF_W),
        .REG_AW (REG_AW)
    ) u_wr_ctrl (
        .wr_en     (wr_en),
        .wr_kind   (wr_kind),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cur_lo    (cur_lo),
        .cur_hi    (cur_hi),
        .lo_en     (lo_en),
        .hi_en     (hi_en),
        .all_banks (all_banks),
        .reg_idx   (reg_idx),
        .lo_val    (lo_val),
        .hi_val    (hi_val)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rfb_bank #(
            .HALF_W   (HALF_W),
            .NUM_REGS (NUM_REGS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (all_banks || (active_bank == BANK_W'(b))),
            .lo_en   (lo_en),
            .hi_en   (hi_en),
            .reg_idx (reg_idx),
            .lo_val  (lo_val),
            .hi_val  (hi_val),
            .halves  (bank_halves[b])
        );
    end

    assign rd_addr_arr[0] = rd_addr_a;
    assign rd_addr_arr[1] = rd_addr_b;
    assign rd_addr_arr[2] = rd_addr_c;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rfb_read_port #(
            .HALF_W   (HALF_W),
            .NUM_REGS (NUM_REGS)
        ) u_rd (
            .halves  (active_halves),
            .rd_addr (rd_addr_arr[p]),
            .lo_en   (lo_en),
            .hi_en   (hi_en),
            .reg_idx (reg_idx),
            .lo_val  (lo_val),
            .hi_val  (hi_val),
            .rd_data (rd_data_arr[p])
        );
    end

    assign rd_data_a = rd_data_arr[0];
    assign rd_data_b = rd_data_arr[1];
    assign rd_data_c = rd_data_arr[2];
endmodule

// File: rtl/rfb_checker.sv
// Module rfb_checker
// Temporal checks on the register file ports and its active-bank register.
// Assumes it is bound into rfb_regfile.
module rfb_checker #(
    parameter int HALF_W  = 16,
    parameter int HALF_AW = 6,
    parameter int BANK_W  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           wr_kind,
    input logic [HALF_AW-1:0]   wr_addr,
    input logic [2*HALF_W-1:0]  wr_data,
    input logic                 bank_sw_en,
    input logic [BANK_W-1:0]    bank_sw_val,
    input logic [HALF_AW-1:0]   rd_addr_a,
    input logic [HALF_W-1:0]    rd_data_a,
    input logic [HALF_AW-1:0]   rd_addr_b,
    input logic [HALF_W-1:0]    rd_data_b,
    input logic [BANK_W-1:0]    active_bank
);
    AST_RESET_BANK: assert property (@(posedge clk)
        !rst_n |=> (active_bank == '0)); // R1

    AST_REG0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a[HALF_AW-1:1] == '0) |-> (rd_data_a == '0)); // R5

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_kind == 2'd0) && (rd_addr_b == wr_addr)
         && (wr_addr[HALF_AW-1:1] != '0))
        |-> (rd_data_b == wr_data[HALF_W-1:0])); // R6

    AST_HALF_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_kind == 2'd0) && !bank_sw_en && (wr_addr[HALF_AW-1:1] != '0))
        |=> (wr_en || (rd_addr_a != $past(wr_addr))
             || (rd_data_a == $past(wr_data[HALF_W-1:0])))); // R2

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sw_en |=> (active_bank == $past(bank_sw_val))); // R8

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_sw_en |=> $stable(active_bank)); // R8
endmodule

bind rfb_regfile rfb_checker #(
    .HALF_W  (HALF_W),
    .HALF_AW (HALF_AW),
    .BANK_W  (BANK_W)
) u_rfb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_kind     (wr_kind),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .bank_sw_en  (bank_sw_en),
    .bank_sw_val (bank_sw_val),
    .rd_addr_a   (rd_addr_a),
    .rd_data_a   (rd_data_a),
    .rd_addr_b   (rd_addr_b),
    .rd_data_b   (rd_data_b),
    .active_bank (active_bank)
);

// File: tb/rfb_regfile_bench.sv
// Directed bench for rfb_regfile: one task per scenario, each self-checking.
module rfb_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd3;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        bank_sw_en = 1'b0;
    logic [1:0]  bank_sw_val = '0;
    logic [5:0]  rd_addr_a = '0, rd_addr_b = '0, rd_addr_c = '0;
    logic [15:0] rd_data_a, rd_data_b, rd_data_c;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfb_regfile u_rfb_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_kind     (wr_kind),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .bank_sw_en  (bank_sw_en),
        .bank_sw_val (bank_sw_val),
        .rd_addr_a   (rd_addr_a),
        .rd_addr_b   (rd_addr_b),
        .rd_addr_c   (rd_addr_c),
        .rd_data_a   (rd_data_a),
        .rd_data_b   (rd_data_b),
        .rd_data_c   (rd_data_c)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        wr_en      = 1'b0;
        wr_kind    = 2'd3;
        bank_sw_en = 1'b0;
    endtask

    // Present a write for one cycle; it lands at the following rising edge.
    task automatic write_op(input logic [1:0] kind, input logic [5:0] addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = kind; wr_addr = addr; wr_data = data;
        @(negedge clk);
        go_idle();
    endtask

    task automatic switch_bank(input logic [1:0] val);
        @(negedge clk);
        bank_sw_en = 1'b1; bank_sw_val = val;
        @(negedge clk);
        go_idle();
    endtask

    // Read one half on port A in a cycle with no write and check it.
    task automatic read_chk(input string tag, input logic [5:0] addr, input logic [15:0] exp);
        @(negedge clk);
        rd_addr_a = addr;
        #1;
        check(tag, rd_data_a, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rd_addr_a = {5'd1, 1'b0}; rd_addr_b = {5'd17, 1'b1}; rd_addr_c = {5'd31, 1'b1};
        #1;
        check("R1 reset port A", rd_data_a, 16'h0000);
        check("R1 reset port B", rd_data_b, 16'h0000);
        check("R1 reset port C", rd_data_c, 16'h0000);
    endtask

    task automatic t_half_write();
        write_op(2'd0, {5'd3, 1'b1}, 32'hFFFF_BEEF);
        read_chk("R2 half write stored", {5'd3, 1'b1}, 16'hBEEF);
        read_chk("R2 other half untouched", {5'd3, 1'b0}, 16'h0000);
    endtask

    task automatic t_full_write();
        write_op(2'd1, {5'd5, 1'b1}, 32'h1234_5678);
        @(negedge clk);
        rd_addr_a = {5'd5, 1'b0}; rd_addr_b = {5'd5, 1'b1}; rd_addr_c = {5'd3, 1'b1};
        #1;
        check("R3 full write low half", rd_data_a, 16'h5678);
        check("R3 full write high half", rd_data_b, 16'h1234);
        check("R7 third port independent", rd_data_c, 16'hBEEF);
    endtask

    task automatic t_write_through();
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 2'd0; wr_addr = {5'd7, 1'b0}; wr_data = 32'h0000_A5A5;
        rd_addr_a = {5'd7, 1'b0}; rd_addr_b = {5'd7, 1'b0}; rd_addr_c = {5'd7, 1'b0};
        #1;
        check("R6 bypass port A", rd_data_a, 16'hA5A5);
        check("R6 bypass port B", rd_data_b, 16'hA5A5);
        check("R6 bypass port C", rd_data_c, 16'hA5A5);
        @(negedge clk);
        wr_kind = 2'd1; wr_addr = {5'd0, 1'b0}; wr_data = 32'hFFFF_FFFF;
        rd_addr_a = {5'd0, 1'b0}; rd_addr_b = {5'd0, 1'b1};
        #1;
        check("R6 R5 bypass of reg0 low", rd_data_a, 16'h0000);
        check("R6 R5 bypass of reg0 high", rd_data_b, 16'h0000);
        @(negedge clk);
        go_idle();
    endtask

    task automatic t_reg_zero();
        write_op(2'd0, {5'd0, 1'b1}, 32'h0000_C3C3);
        read_chk("R5 reg0 high after half write", {5'd0, 1'b1}, 16'h0000);
        read_chk("R5 reg0 low after full write", {5'd0, 1'b0}, 16'h0000);
    endtask

    task automatic t_banks();
        switch_bank(2'd1);
        read_chk("R4 full write high half not in bank 1", {5'd5, 1'b1}, 16'h0000);
        read_chk("R2 half write not in bank 1", {5'd3, 1'b1}, 16'h0000);
        write_op(2'd0, {5'd3, 1'b1}, 32'h0000_1111);
        // Switch back to bank 0 while writing: the write belongs to bank 1.
        @(negedge clk);
        bank_sw_en = 1'b1; bank_sw_val = 2'd0;
        wr_en = 1'b1; wr_kind = 2'd0; wr_addr = {5'd9, 1'b0}; wr_data = 32'h0000_2222;
        @(negedge clk);
        go_idle();
        read_chk("R8 switch-cycle write not in new bank", {5'd9, 1'b0}, 16'h0000);
        read_chk("R2 bank 0 kept its half", {5'd3, 1'b1}, 16'hBEEF);
        read_chk("R4 bank 0 kept full write high half", {5'd5, 1'b1}, 16'h1234);
        switch_bank(2'd1);
        read_chk("R8 switch-cycle write in old bank", {5'd9, 1'b0}, 16'h2222);
        read_chk("R2 bank 1 half write", {5'd3, 1'b1}, 16'h1111);
    endtask

    task automatic t_copy();
        switch_bank(2'd0);
        write_op(2'd2, {5'd5, 1'b1}, 32'hDEAD_DEAD);
        read_chk("R9 copy ignores write data", {5'd5, 1'b0}, 16'h5678);
        switch_bank(2'd2);
        read_chk("R9 copy high half in bank 2", {5'd5, 1'b1}, 16'h1234);
        switch_bank(2'd3);
        read_chk("R9 copy low half in bank 3", {5'd5, 1'b0}, 16'h5678);
        switch_bank(2'd1);
        read_chk("R9 copy high half in bank 1", {5'd5, 1'b1}, 16'h1234);
    endtask

    task automatic t_reserved();
        write_op(2'd3, {5'd9, 1'b0}, 32'h0000_7777);
        read_chk("R10 reserved kind keeps value", {5'd9, 1'b0}, 16'h2222);
        write_op(2'd3, {5'd10, 1'b0}, 32'h0000_7777);
        read_chk("R10 reserved kind writes nothing", {5'd10, 1'b0}, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        go_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_half_write();
        t_full_write();
        t_write_through();
        t_reg_zero();
        t_banks();
        t_copy();
        t_reserved();
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule